// File: doc/BRIEF.md
# Ripple Binary Counter with Toggle Stages

This block counts falling edges of an input clock with a chain of divide-by-two stages. Each stage is a JK-style storage element whose J and K inputs are tied high, so every falling edge on its clock inverts it. Stage 0 takes the external clock. Each later stage takes the true output of the stage below it as its clock. The outputs therefore settle one stage at a time after each input edge, and together they read as an unsigned binary count. A shared active-low clear empties every stage at once, without waiting for a clock edge. The block is used as a low-cost event or frequency divider where the reader can wait for the chain to settle.

The single stage is also a reusable module with its own J and K inputs. Its state machine has two states, `ST_ZERO` (output low) and `ST_ONE` (output high). The transitions are chosen by the mode `{J,K}`:

- `JK_HOLD` (00): stays in the current state.
- `JK_RESET` (01): goes to `ST_ZERO`.
- `JK_SET` (10): goes to `ST_ONE`.
- `JK_TOGGLE` (11): `ST_ZERO` goes to `ST_ONE` and `ST_ONE` goes to `ST_ZERO`.

The clear takes the stage to `ST_ZERO` from either state.

Top module: `ripple_counter`

## Requirements
- R1: While `clr_n` is low, `cnt_o` is 0 and `cnt_n_o` is all ones. This takes effect at once, with no clock edge, and holds whatever the input clock does.
- R2: In a single stage with the clear high and J=0, K=0, a falling clock edge leaves Q unchanged.
- R3: In a single stage with the clear high and J=1, K=0, a falling clock edge makes Q=1.
- R4: In a single stage with the clear high and J=0, K=1, a falling clock edge makes Q=0.
- R5: In a single stage with the clear high and J=1, K=1, each falling clock edge inverts Q, so Q runs at half the clock frequency.
- R6: A stage changes state only on a falling edge of its clock. A rising edge has no effect, even with J=K=1.
- R7: For k ≥ 1, bit k of `cnt_o` inverts exactly when bit k-1 falls from 1 to 0. Bit 0 inverts on every falling edge of `clk_in`.
- R8: With `clr_n` high, `cnt_o` (bit 0 the least significant) rises by one for each falling edge of `clk_in`. The first falling edge after release gives 1.
- R9: The count wraps from 255 to 0 on the next falling edge.
- R10: Once settled, `cnt_n_o` equals the bitwise inverse of `cnt_o`.
- R11: In a single stage, a low clear forces Q=0 and Q̄=1 at once, and overrides clock edges with J=K=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Counted clock; stage 0 acts on its falling edge |
| clr_n | input | 1 | Asynchronous active-low clear of all stages |
| cnt_o | output | STAGES (8) | True stage outputs, bit 0 least significant |
| cnt_n_o | output | STAGES (8) | Complementary stage outputs |

## Verification
The clear and the counting edge can land in the same instant. The bench provokes this by pulling `clr_n` low in the same time step as a falling edge of `clk_in`, at a moment when the count would otherwise advance. It then judges that the count reads zero one nanosecond later and stays zero across further edges, whichever of the two events the simulator processes first. Release is placed in the clock's high phase, and the bench requires the first following falling edge to produce exactly 1.

// File: rtl/ripple_counter_pkg.sv
`timescale 1ns/1ps
package ripple_counter_pkg;

    // Two-state storage of one toggle stage.
    typedef enum logic {
        ST_ZERO = 1'b0,
        ST_ONE  = 1'b1
    } stage_state_e;

    // Stage control mode, encoded as {J,K}.
    typedef enum logic [1:0] {
        JK_HOLD   = 2'b00,
        JK_RESET  = 2'b01,
        JK_SET    = 2'b10,
        JK_TOGGLE = 2'b11
    } jk_mode_e;

endpackage

// File: rtl/jk_stage.sv
`timescale 1ns/1ps
module jk_stage
    import ripple_counter_pkg::*;
(
    input  logic clk_i,
    input  logic clr_ni,
    input  logic j_i,
    input  logic k_i,
    output logic q_o,
    output logic qn_o
);

    stage_state_e state_q;
    stage_state_e state_nx;
    jk_mode_e     mode;

    assign mode = jk_mode_e'({j_i, k_i});

    // Next-state selection from the JK mode
    always_comb begin
        state_nx = state_q;
        unique case (mode)
            JK_HOLD:   state_nx = state_q;
            JK_RESET:  state_nx = ST_ZERO;
            JK_SET:    state_nx = ST_ONE;
            JK_TOGGLE: state_nx = (state_q == ST_ONE) ? ST_ZERO : ST_ONE;
            default:   state_nx = state_q;
        endcase
    end

    // State register: falling-edge clocked, asynchronous active-low clear
    always_ff @(negedge clk_i or negedge clr_ni) begin
        if (!clr_ni) begin
            state_q <= ST_ZERO;
        end else begin
            state_q <= state_nx;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_ZERO: begin
                q_o  = 1'b0;
                qn_o = 1'b1;
            end
            ST_ONE: begin
                q_o  = 1'b1;
                qn_o = 1'b0;
            end
            default: begin
                q_o  = 1'b0;
                qn_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/toggle_chain.sv
`timescale 1ns/1ps
module toggle_chain #(
    parameter int STAGES = 8
) (
    input  logic              clk_i,
    input  logic              clr_ni,
    output logic [STAGES-1:0] q_o,
    output logic [STAGES-1:0] qn_o
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] stage_clk;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // Stage 0 takes the input clock; every later stage rides on the
        // true output of the stage below it.
        if (i == 0) begin : g_first
            assign stage_clk[i] = clk_i;
        end else begin : g_next
            assign stage_clk[i] = q_o[i-1];
        end

        jk_stage u_stage (
            .clk_i  (stage_clk[i]),
            .clr_ni (clr_ni),
            .j_i    (1'b1),
            .k_i    (1'b1),
            .q_o    (q_o[i]),
            .qn_o   (qn_o[i])
        );
    end

endmodule

// File: rtl/ripple_counter.sv
`timescale 1ns/1ps
module ripple_counter #(
    parameter int STAGES = 8
) (
    input  logic              clk_in,
    input  logic              clr_n,
    output logic [STAGES-1:0] cnt_o,
    output logic [STAGES-1:0] cnt_n_o
);

    toggle_chain #(
        .STAGES (STAGES)
    ) u_chain (
        .clk_i  (clk_in),
        .clr_ni (clr_n),
        .q_o    (cnt_o),
        .qn_o   (cnt_n_o)
    );

endmodule

// File: rtl/ripple_counter_chk.sv
`timescale 1ns/1ps
module ripple_counter_chk #(
    parameter int STAGES = 8
) (
    input logic              clk_in,
    input logic              clr_n,
    input logic [STAGES-1:0] cnt_o,
    input logic [STAGES-1:0] cnt_n_o
);

    // Sampling on the rising edge, half a period after the counting edge,
    // so the ripple has settled. armed means the previous sample was also
    // taken with the clear high.
    logic armed;

    always_ff @(posedge clk_in or negedge clr_n) begin
        if (!clr_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    // R1: clear holds the count empty
    always_ff @(posedge clk_in) begin
        if (!clr_n) begin
            a_clear_empty_r1: assert (cnt_o == '0 && cnt_n_o == '1)
                else $error("R1 clear not holding zero");
        end
    end

    // R8: one increment per falling edge
    p_increment_r8: assert property (@(posedge clk_in) disable iff (!clr_n)
        armed |-> (cnt_o == STAGES'($past(cnt_o) + 1'b1)));

    // R7: bit 0 inverts on every input falling edge
    p_lsb_toggle_r7: assert property (@(posedge clk_in) disable iff (!clr_n)
        armed |-> (cnt_o[0] != $past(cnt_o[0])));

    // R9: all ones rolls over to zero
    p_wrap_r9: assert property (@(posedge clk_in) disable iff (!clr_n)
        (armed && $past(cnt_o) == '1) |-> (cnt_o == '0));

    // R10: complementary outputs
    p_complement_r10: assert property (@(posedge clk_in) disable iff (!clr_n)
        cnt_n_o == ~cnt_o);

endmodule

bind ripple_counter ripple_counter_chk #(
    .STAGES (STAGES)
) u_chk (
    .clk_in  (clk_in),
    .clr_n   (clr_n),
    .cnt_o   (cnt_o),
    .cnt_n_o (cnt_n_o)
);

// File: tb/ripple_counter_tb.sv
`timescale 1ns/1ps
module ripple_counter_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic [W-1:0] cnt, cnt_n;

    logic stg_clk = 1'b0, stg_clr_n = 1'b0, stg_j = 1'b0, stg_k = 1'b0;
    logic stg_q, stg_qn;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    ripple_counter #(.STAGES(W)) u_dut (
        .clk_in (clk), .clr_n (clr_n), .cnt_o (cnt), .cnt_n_o (cnt_n)
    );

    jk_stage u_stage (
        .clk_i (stg_clk), .clr_ni (stg_clr_n), .j_i (stg_j), .k_i (stg_k),
        .q_o (stg_q), .qn_o (stg_qn)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // sample point: 1 ns after a rising edge
    task automatic at_sample();
        @(posedge clk);
        #1;
    endtask

    task automatic do_clear_release();
        clr_n = 1'b0;
        at_sample();
        clr_n = 1'b1;   // released in high phase
    endtask

    task automatic stg_fall();
        stg_clk = 1'b1; #2;
        stg_clk = 1'b0; #2;
    endtask

    task automatic t_reset_state();
        at_sample();
        chk("R1 reset cnt", int'(cnt), 0);
        chk("R1 reset cnt_n", int'(cnt_n), 255);
    endtask

    task automatic t_count_and_ripple();
        logic [W-1:0] prev;
        do_clear_release();
        prev = '0;
        for (int i = 1; i <= 300; i++) begin
            at_sample();
            chk("R8 count", int'(cnt), i % 256);
            chk("R10 complement", int'(cnt_n), int'(~cnt) & 255);
            for (int b = 1; b < W; b++) begin
                if ((cnt[b] != prev[b]) != (prev[b-1] && !cnt[b-1])) begin
                    chk("R7 ripple bit", b, -1);
                end
            end
            chk("R7 bit0 toggles", int'(cnt[0] != prev[0]), 1);
            prev = cnt;
        end
    endtask

    task automatic t_wrap();
        do_clear_release();
        repeat (255) at_sample();
        chk("R9 at 255", int'(cnt), 255);
        at_sample();
        chk("R9 wraps to 0", int'(cnt), 0);
        at_sample();
        chk("R9 after wrap", int'(cnt), 1);
    endtask

    task automatic t_async_clear();
        do_clear_release();
        repeat (5) at_sample();
        chk("R8 before clear", int'(cnt), 5);
        #1 clr_n = 1'b0;   // mid high phase, no edge
        #1;
        chk("R1 async clear", int'(cnt), 0);
        chk("R1 async clear cnt_n", int'(cnt_n), 255);
        repeat (3) at_sample();
        chk("R1 held through edges", int'(cnt), 0);
        clr_n = 1'b1;
        at_sample();
        chk("R8 first edge after release", int'(cnt), 1);
    endtask

    task automatic t_clear_on_edge();
        do_clear_release();
        repeat (7) at_sample();
        @(negedge clk);
        clr_n = 1'b0;      // same time step as counting edge
        #1;
        chk("R1 clear with edge", int'(cnt), 0);
        at_sample();
        chk("R1 clear with edge held", int'(cnt), 0);
        clr_n = 1'b1;
        at_sample();
        chk("R8 release after coincident clear", int'(cnt), 1);
    endtask

    task automatic t_stage_modes();
        stg_clr_n = 1'b0; #2;
        chk("R11 stage clear q", int'(stg_q), 0);
        chk("R11 stage clear qn", int'(stg_qn), 1);
        stg_clr_n = 1'b1; #2;
        stg_j = 1'b1; stg_k = 1'b0; stg_fall();
        chk("R3 set", int'(stg_q), 1);
        chk("R3 set qn", int'(stg_qn), 0);
        stg_j = 1'b0; stg_k = 1'b0; stg_fall();
        chk("R2 hold high", int'(stg_q), 1);
        stg_j = 1'b0; stg_k = 1'b1; stg_fall();
        chk("R4 reset", int'(stg_q), 0);
        stg_j = 1'b0; stg_k = 1'b0; stg_fall();
        chk("R2 hold low", int'(stg_q), 0);
        stg_j = 1'b1; stg_k = 1'b1;
        stg_fall();
        chk("R5 toggle 1", int'(stg_q), 1);
        stg_fall();
        chk("R5 toggle 2", int'(stg_q), 0);
        stg_fall();
        chk("R5 toggle 3", int'(stg_q), 1);
        stg_clk = 1'b1; #2;
        chk("R6 rising edge ignored", int'(stg_q), 1);
        stg_clk = 1'b0; #2;
        chk("R6 falling edge acts", int'(stg_q), 0);
        stg_fall();
        chk("R5 toggle 4", int'(stg_q), 1);
        stg_clr_n = 1'b0; #1;
        chk("R11 async stage clear", int'(stg_q), 0);
        stg_fall();
        stg_fall();
        chk("R11 clear overrides toggle", int'(stg_q), 0);
        chk("R11 clear overrides toggle qn", int'(stg_qn), 1);
    endtask

    initial begin
        #1_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        t_reset_state();
        t_stage_modes();
        t_count_and_ripple();
        t_wrap();
        t_async_clear();
        t_clear_on_edge();
        summary();
    end

endmodule